// File: doc/BRIEF.md
# Five-Stage Multicycle Integer Processor

This block is a small 32-bit integer processor that runs one instruction at a time. Each instruction passes through up to five stages: fetch, decode with register read, execute or address generation, memory access or branch completion, and register write-back. Each stage hands its results to the next through a set of internal holding registers: the fetched word, the next sequential address, two source operands, the sign-extended immediate, the execute result, the branch condition and the loaded word. A finite-state controller steps through these stages. Stages that an instruction does not need are skipped, so simple instructions finish sooner.

The core has one memory port for both instruction fetch and data access. The port carries a byte address, write data, a write strobe, a fetch indicator and read data. Read data must arrive in the same cycle as the address. Addresses are byte addresses and every access is one aligned 32-bit word. A synchronous reset clears the program counter and the register file.

Top module: `mc5_core`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `mem_addr` is 0, `mem_fetch` is 1 and `mem_we` is 0. The first instruction is therefore fetched from address 0.
- R2: Each instruction is fetched in one cycle, with `mem_fetch` high and the program counter on `mem_addr`. When no branch is taken, the next fetch address is the previous one plus 4.
- R3: Instruction fields are taken from fixed positions. The opcode is in [31:26], the first source register in [25:21], the second source register (also the destination for immediate ops and loads) in [20:16], the destination for register-register ops in [15:11] and the function code in [5:0]. The 16-bit immediate in [15:0] is always sign-extended.
- R4: Opcode 0 selects a register-register operation by its function code: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x26 xor, 0x04 shift left, 0x06 logical shift right, 0x07 arithmetic shift right. Shift amounts use the low 5 bits of the second operand.
- R5: The compare operations write 1 when the signed relation holds and 0 when it does not. The register-register function codes are 0x28 equal, 0x29 not equal, 0x2A less, 0x2B greater, 0x2C less-or-equal and 0x2D greater-or-equal. The immediate opcodes are 0x18 to 0x1D in the same relation order.
- R6: The immediate opcodes apply the same operation to the first source and the immediate: 0x08 add, 0x0A subtract, 0x0C and, 0x0D or, 0x0E xor, 0x14 shift left, 0x16 logical shift right, 0x17 arithmetic shift right.
- R7: Register 0 always reads as zero. Writes to it from any instruction type have no effect.
- R8: Load (opcode 0x23) reads the word at first-source plus immediate into the register at [20:16]. Store (opcode 0x2B) writes the second-source register to first-source plus immediate.
- R9: Branch-if-zero (opcode 0x04) and branch-if-nonzero (opcode 0x05) test the first source. A taken branch continues at the branch's address plus 4 plus the immediate. A branch that is not taken continues at its address plus 4.
- R10: Fetch-to-fetch cycle counts are fixed by instruction type: 4 for ALU ops, 5 for loads, 4 for stores and branches, and 3 for an undefined opcode or function code. An undefined instruction changes nothing except advancing the program counter by 4.
- R11: `mem_we` is high for exactly one cycle per store, in its memory stage. Loads and all other instructions never write memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_rdata | input | 32 | Memory read data, valid in the same cycle as the address |
| mem_addr | output | 32 | Byte address: program counter during fetch, computed address during the data stage |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Memory write strobe |
| mem_fetch | output | 1 | High during an instruction fetch cycle |

## Verification
The hardest case to reach from the ports is the per-type cycle count, because no port marks when an instruction finishes. The bench records the cycle of every `mem_fetch` pulse across a mixed sequence and compares the gaps. That sequence contains an ALU op, a load, a store, a branch and an undefined word. Register contents can only be seen through stores. Every scenario therefore ends by storing its results into a data region of the bench's memory model, which the bench then reads. Branch direction is shown by writes placed on taken and skipped paths, including a backward loop that must run exactly three times.

// File: rtl/mc5_pkg.sv
package mc5_pkg;
  localparam int XLEN = 32;

  typedef enum logic [2:0] {K_NOP, K_RR, K_RI, K_LD, K_ST, K_BR} kind_t;
  typedef enum logic [3:0] {
    A_ADD, A_SUB, A_AND, A_OR, A_XOR, A_SLL, A_SRL, A_SRA,
    A_SEQ, A_SNE, A_SLT, A_SGT, A_SLE, A_SGE
  } aluop_t;
  typedef enum logic [2:0] {S_IF, S_ID, S_EX, S_MEM, S_WB} state_t;

  typedef struct packed {
    kind_t  kind;
    aluop_t op;
    logic   br_nz;
  } dec_t;

  localparam logic [5:0] OP_RR   = 6'h00;
  localparam logic [5:0] OP_BZ   = 6'h04;
  localparam logic [5:0] OP_BNZ  = 6'h05;
  localparam logic [5:0] OP_LW   = 6'h23;
  localparam logic [5:0] OP_SW   = 6'h2B;

  function automatic aluop_t func_to_op(input logic [5:0] f, output logic ok);
    ok = 1'b1;
    case (f)
      6'h20: return A_ADD;
      6'h22: return A_SUB;
      6'h24: return A_AND;
      6'h25: return A_OR;
      6'h26: return A_XOR;
      6'h04: return A_SLL;
      6'h06: return A_SRL;
      6'h07: return A_SRA;
      6'h28: return A_SEQ;
      6'h29: return A_SNE;
      6'h2A: return A_SLT;
      6'h2B: return A_SGT;
      6'h2C: return A_SLE;
      6'h2D: return A_SGE;
      default: begin ok = 1'b0; return A_ADD; end
    endcase
  endfunction

  function automatic aluop_t imm_to_op(input logic [5:0] o, output logic ok);
    ok = 1'b1;
    case (o)
      6'h08: return A_ADD;
      6'h0A: return A_SUB;
      6'h0C: return A_AND;
      6'h0D: return A_OR;
      6'h0E: return A_XOR;
      6'h14: return A_SLL;
      6'h16: return A_SRL;
      6'h17: return A_SRA;
      6'h18: return A_SEQ;
      6'h19: return A_SNE;
      6'h1A: return A_SLT;
      6'h1B: return A_SGT;
      6'h1C: return A_SLE;
      6'h1D: return A_SGE;
      default: begin ok = 1'b0; return A_ADD; end
    endcase
  endfunction

  function automatic dec_t decode(input logic [31:0] ir);
    dec_t d;
    logic ok;
    d.kind  = K_NOP;
    d.op    = A_ADD;
    d.br_nz = 1'b0;
    case (ir[31:26])
      OP_RR: begin
        d.op = func_to_op(ir[5:0], ok);
        if (ok) d.kind = K_RR;
      end
      OP_BZ:  d.kind = K_BR;
      OP_BNZ: begin d.kind = K_BR; d.br_nz = 1'b1; end
      OP_LW:  d.kind = K_LD;
      OP_SW:  d.kind = K_ST;
      default: begin
        d.op = imm_to_op(ir[31:26], ok);
        if (ok) d.kind = K_RI;
      end
    endcase
    return d;
  endfunction

  function automatic logic [XLEN-1:0] alu_calc(input aluop_t op,
                                               input logic [XLEN-1:0] x,
                                               input logic [XLEN-1:0] y);
    logic signed [XLEN-1:0] sx, sy;
    sx = x;
    sy = y;
    case (op)
      A_ADD: return x + y;
      A_SUB: return x - y;
      A_AND: return x & y;
      A_OR:  return x | y;
      A_XOR: return x ^ y;
      A_SLL: return x << y[4:0];
      A_SRL: return x >> y[4:0];
      A_SRA: return sx >>> y[4:0];
      A_SEQ: return {{(XLEN-1){1'b0}}, x == y};
      A_SNE: return {{(XLEN-1){1'b0}}, x != y};
      A_SLT: return {{(XLEN-1){1'b0}}, sx < sy};
      A_SGT: return {{(XLEN-1){1'b0}}, sx > sy};
      A_SLE: return {{(XLEN-1){1'b0}}, sx <= sy};
      A_SGE: return {{(XLEN-1){1'b0}}, sx >= sy};
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/mc5_regfile.sv
module mc5_regfile #(
  parameter int NREG = 32,
  parameter int DW   = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [$clog2(NREG)-1:0] ra1,
  input  logic [$clog2(NREG)-1:0] ra2,
  output logic [DW-1:0]           rd1,
  output logic [DW-1:0]           rd2,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] wa,
  input  logic [DW-1:0]           wd
);
  localparam int AW = $clog2(NREG);

  logic [DW-1:0] regs [1:NREG-1];

  // Entry 0 has no storage: reads give zero, writes go nowhere.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 1; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

  // R7: a write aimed at register 0 leaves a later zero read intact
  p_r0_stays_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (we && wa == '0 && ra1 == '0) |=> (ra1 != '0 || rd1 == '0));

  logic unused_aw;
  assign unused_aw = (AW == 0);
endmodule

// File: rtl/mc5_alu.sv
module mc5_alu
  import mc5_pkg::*;
(
  input  aluop_t          op,
  input  logic [XLEN-1:0] x,
  input  logic [XLEN-1:0] y,
  output logic [XLEN-1:0] res
);
  assign res = alu_calc(op, x, y);
endmodule

// File: rtl/mc5_ctrl.sv
module mc5_ctrl
  import mc5_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  kind_t  kind,
  output state_t st,
  output logic   done
);
  state_t nxt;

  always_comb begin
    nxt  = st;
    done = 1'b0;
    case (st)
      S_IF: nxt = S_ID;
      S_ID: nxt = S_EX;
      S_EX: begin
        case (kind)
          K_RR, K_RI:       nxt = S_WB;
          K_LD, K_ST, K_BR: nxt = S_MEM;
          default: begin nxt = S_IF; done = 1'b1; end
        endcase
      end
      S_MEM: begin
        if (kind == K_LD) nxt = S_WB;
        else begin nxt = S_IF; done = 1'b1; end
      end
      S_WB: begin nxt = S_IF; done = 1'b1; end
      default: nxt = S_IF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= S_IF;
    else     st <= nxt;
  end

  // R10: decode always leads into execute
  p_ex_after_id_r10: assert property (@(posedge clk) disable iff (rst)
    (st == S_ID) |=> (st == S_EX));
  // R10: a completed instruction is followed by a fetch
  p_fetch_after_done_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> (st == S_IF));
endmodule

// File: rtl/mc5_core.sv
module mc5_core
  import mc5_pkg::*;
#(
  parameter int          NREG     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] mem_rdata,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        mem_we,
  output logic        mem_fetch
);
  localparam int RAW = $clog2(NREG);

  logic [XLEN-1:0] pc, npc, ir, a, b, imm, aluout, lmd;
  logic            cond;
  state_t          st;
  logic            done;
  dec_t            dec;
  logic [XLEN-1:0] rd1, rd2, alu_y, alu_res, wb_data;
  logic [RAW-1:0]  wb_addr;
  logic            wb_en;
  logic            br_taken;

  assign dec = decode(ir);

  mc5_ctrl u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .kind (dec.kind),
    .st   (st),
    .done (done)
  );

  mc5_regfile #(.NREG(NREG), .DW(XLEN)) u_rf (
    .clk (clk),
    .rst (rst),
    .ra1 (ir[21 +: RAW]),
    .ra2 (ir[16 +: RAW]),
    .rd1 (rd1),
    .rd2 (rd2),
    .we  (wb_en),
    .wa  (wb_addr),
    .wd  (wb_data)
  );

  assign alu_y = (dec.kind == K_RR) ? b : imm;

  mc5_alu u_alu (
    .op  (dec.op),
    .x   (a),
    .y   (alu_y),
    .res (alu_res)
  );

  // Memory port: fetch uses PC, data stage uses the computed address
  assign mem_fetch = (st == S_IF);
  assign mem_addr  = mem_fetch ? pc : aluout;
  assign mem_we    = (st == S_MEM) && (dec.kind == K_ST);
  assign mem_wdata = b;

  // Write-back: destination field depends on instruction type
  assign wb_en   = (st == S_WB);
  assign wb_addr = (dec.kind == K_RR) ? ir[11 +: RAW] : ir[16 +: RAW];
  assign wb_data = (dec.kind == K_LD) ? lmd : aluout;

  assign br_taken = (dec.kind == K_BR) && cond;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= RESET_PC;
      npc    <= '0;
      ir     <= '0;
      a      <= '0;
      b      <= '0;
      imm    <= '0;
      aluout <= '0;
      cond   <= 1'b0;
      lmd    <= '0;
    end else begin
      case (st)
        S_IF: begin
          ir  <= mem_rdata;
          npc <= pc + 32'd4;
        end
        S_ID: begin
          a   <= rd1;
          b   <= rd2;
          imm <= {{(XLEN-16){ir[15]}}, ir[15:0]};
        end
        S_EX: begin
          case (dec.kind)
            K_LD, K_ST: aluout <= a + imm;
            K_RR, K_RI: aluout <= alu_res;
            K_BR: begin
              aluout <= npc + imm;
              cond   <= dec.br_nz ? (a != '0) : (a == '0);
            end
            default: ;
          endcase
        end
        S_MEM: begin
          if (dec.kind == K_LD) lmd <= mem_rdata;
        end
        default: ;
      endcase
      if (done) pc <= br_taken ? aluout : npc;
    end
  end

  // R2: the sequential address is captured from the fetch address
  p_seq_addr_r2: assert property (@(posedge clk) disable iff (rst)
    mem_fetch |=> (npc == $past(pc) + 32'd4));
  // R10: the PC moves only at instruction completion
  p_pc_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(pc));
  // R3: the immediate seen by execute is a sign extension
  p_imm_sext_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_EX) |-> (imm[31:16] == {16{imm[15]}}));
  // R9: a taken branch redirects to the computed target
  p_br_target_r9: assert property (@(posedge clk) disable iff (rst)
    (done && br_taken) |=> (pc == $past(aluout)));
  // R11: a store strobe lasts a single cycle
  p_we_single_r11: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
endmodule

// File: tb/mc5_core_bench.sv
module mc5_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic        mem_we, mem_fetch;

  int total = 0;
  int bad   = 0;
  int pa    = 0;
  logic finished = 1'b0;

  logic [31:0] mem [0:255];

  always #2.5 clk = ~clk;

  mc5_core u_mc5_core (
    .clk       (clk),
    .rst       (rst),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_fetch (mem_fetch)
  );

  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;

  // Encoders follow the field positions of R3
  function automatic logic [31:0] rr(input logic [5:0] f, input int rd, input int s1, input int s2);
    return {6'h00, s1[4:0], s2[4:0], rd[4:0], 5'd0, f};
  endfunction
  function automatic logic [31:0] ri(input logic [5:0] op, input int rt, input int s1, input logic [15:0] im);
    return {op, s1[4:0], rt[4:0], im};
  endfunction
  localparam logic [31:0] HALT = {6'h04, 5'd0, 5'd0, 16'hFFFC};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic emit(input logic [31:0] w);
    mem[pa >> 2] = w;
    pa += 4;
  endtask

  task automatic begin_prog();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    pa = 0;
  endtask

  task automatic launch(input int cycles);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  function automatic logic [31:0] rdw(input int byte_addr);
    return mem[byte_addr >> 2];
  endfunction

  task automatic t_reset();
    begin_prog();
    emit(HALT);
    repeat (2) @(negedge clk);
    chk("R1 addr in reset", mem_addr, 32'h0);
    chk("R1 fetch in reset", {31'd0, mem_fetch}, 32'd1);
    chk("R1 we in reset", {31'd0, mem_we}, 32'd0);
    rst = 1'b0;
    chk("R1 addr after release", mem_addr, 32'h0);
    chk("R1 fetch after release", {31'd0, mem_fetch}, 32'd1);
    @(negedge clk);
    chk("R1 fetch drops in decode", {31'd0, mem_fetch}, 32'd0);
  endtask

  task automatic t_rr_ops();
    logic [31:0] exp [8] = '{32'd93, 32'd107, 32'h60, 32'hFFFFFFFD,
                             32'hFFFFFF9D, 32'd800, 32'h1FFFFFFF, 32'hFFFFFFFF};
    logic [5:0] fn [8] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h26, 6'h04, 6'h06, 6'h07};
    begin_prog();
    emit(ri(6'h08, 1, 0, 16'd100));
    emit(ri(6'h08, 2, 0, 16'hFFF9));
    emit(ri(6'h08, 3, 0, 16'd3));
    for (int k = 0; k < 8; k++) begin
      if (k < 5) emit(rr(fn[k], 4 + k, 1, 2));
      else if (k == 5) emit(rr(fn[k], 4 + k, 1, 3));
      else emit(rr(fn[k], 4 + k, 2, 3));
    end
    for (int k = 0; k < 8; k++) emit(ri(6'h2B, 4 + k, 0, 16'h200 + 16'(4 * k)));
    emit(HALT);
    launch(120);
    for (int k = 0; k < 8; k++) chk($sformatf("R4 rr op %0d", k), rdw(32'h200 + 4 * k), exp[k]);
  endtask

  task automatic t_compare();
    logic [31:0] exp [10] = '{1, 1, 1, 0, 1, 0, 1, 0, 1, 0};
    begin_prog();
    emit(ri(6'h08, 1, 0, 16'd5));
    emit(ri(6'h08, 2, 0, 16'hFFFD));
    emit(rr(6'h28, 10, 1, 1));
    emit(rr(6'h29, 11, 1, 2));
    emit(rr(6'h2A, 12, 2, 1));
    emit(rr(6'h2B, 13, 2, 1));
    emit(rr(6'h2C, 14, 1, 1));
    emit(rr(6'h2D, 15, 2, 1));
    emit(ri(6'h1A, 16, 1, 16'd6));
    emit(ri(6'h1B, 17, 1, 16'd6));
    emit(ri(6'h18, 18, 2, 16'hFFFD));
    emit(ri(6'h1D, 19, 2, 16'hFFFE));
    for (int k = 0; k < 10; k++) emit(ri(6'h2B, 10 + k, 0, 16'h240 + 16'(4 * k)));
    emit(HALT);
    launch(150);
    for (int k = 0; k < 10; k++) chk($sformatf("R5 compare %0d", k), rdw(32'h240 + 4 * k), exp[k]);
  endtask

  task automatic t_imm_ops();
    logic [31:0] exp [8] = '{32'hFFFFFFFB, 32'hFFFF8000, 32'hF0, 32'd4,
                             32'hFFFFFFF1, 32'hFFFFFFB0, 32'hF, 32'hFFFFFFFD};
    begin_prog();
    emit(ri(6'h08, 1, 0, 16'hFFFB));
    emit(ri(6'h0D, 2, 0, 16'h8000));
    emit(ri(6'h0C, 3, 1, 16'h00F0));
    emit(ri(6'h0E, 4, 1, 16'hFFFF));
    emit(ri(6'h0A, 5, 1, 16'd10));
    emit(ri(6'h14, 6, 1, 16'd4));
    emit(ri(6'h16, 7, 1, 16'd28));
    emit(ri(6'h17, 8, 1, 16'd1));
    for (int k = 0; k < 8; k++) emit(ri(6'h2B, 1 + k, 0, 16'h280 + 16'(4 * k)));
    emit(HALT);
    launch(100);
    chk("R3 sign-extended add imm", rdw(32'h280), exp[0]);
    chk("R3 sign-extended or imm", rdw(32'h284), exp[1]);
    for (int k = 2; k < 8; k++) chk($sformatf("R6 imm op %0d", k), rdw(32'h280 + 4 * k), exp[k]);
  endtask

  task automatic t_r0();
    begin_prog();
    mem[32'h2F0 >> 2] = 32'hDEADBEEF;
    emit(ri(6'h08, 0, 0, 16'd55));
    emit(ri(6'h2B, 0, 0, 16'h2C0));
    emit(ri(6'h23, 0, 0, 16'h2F0));
    emit(ri(6'h2B, 0, 0, 16'h2C4));
    emit(ri(6'h08, 1, 0, 16'd9));
    emit(rr(6'h20, 0, 1, 1));
    emit(ri(6'h2B, 0, 0, 16'h2C8));
    emit(rr(6'h20, 2, 0, 1));
    emit(ri(6'h2B, 2, 0, 16'h2CC));
    emit(HALT);
    mem[32'h2C0 >> 2] = 32'h1111;
    mem[32'h2C4 >> 2] = 32'h2222;
    mem[32'h2C8 >> 2] = 32'h3333;
    launch(80);
    chk("R7 imm write to r0", rdw(32'h2C0), 32'h0);
    chk("R7 load into r0", rdw(32'h2C4), 32'h0);
    chk("R7 rr write to r0", rdw(32'h2C8), 32'h0);
    chk("R7 r0 as source", rdw(32'h2CC), 32'd9);
  endtask

  task automatic t_load_store();
    begin_prog();
    mem[32'h300 >> 2] = 32'h12345678;
    mem[32'h304 >> 2] = 32'hFFFFFFF0;
    emit(ri(6'h08, 1, 0, 16'h308));
    emit(ri(6'h23, 2, 1, 16'hFFF8));
    emit(ri(6'h23, 3, 1, 16'hFFFC));
    emit(rr(6'h20, 4, 2, 3));
    emit(ri(6'h2B, 4, 1, 16'd4));
    emit(ri(6'h2B, 2, 1, 16'd0));
    emit(HALT);
    launch(60);
    chk("R8 load then add then store", rdw(32'h30C), 32'h12345668);
    chk("R8 store at base", rdw(32'h308), 32'h12345678);
    chk("R11 loaded word untouched", rdw(32'h300), 32'h12345678);
    chk("R11 loaded word untouched 2", rdw(32'h304), 32'hFFFFFFF0);
  endtask

  task automatic t_branches();
    begin_prog();
    emit(ri(6'h08, 2, 0, 16'd1));     // 0
    emit(ri(6'h04, 0, 2, 16'd4));     // 4  bz r2 not taken
    emit(ri(6'h08, 3, 0, 16'h11));    // 8
    emit(ri(6'h05, 0, 2, 16'd4));     // 12 bnz r2 taken -> 20
    emit(ri(6'h08, 3, 0, 16'h22));    // 16 skipped
    emit(ri(6'h2B, 3, 0, 16'h200));   // 20
    emit(ri(6'h04, 0, 0, 16'd8));     // 24 bz r0 taken -> 36
    emit(ri(6'h08, 4, 0, 16'h33));    // 28 skipped
    emit(ri(6'h08, 4, 0, 16'h44));    // 32 skipped
    emit(ri(6'h05, 0, 0, 16'd4));     // 36 bnz r0 not taken
    emit(ri(6'h08, 4, 4, 16'h55));    // 40
    emit(ri(6'h2B, 4, 0, 16'h204));   // 44
    emit(ri(6'h08, 5, 0, 16'd3));     // 48
    emit(ri(6'h08, 6, 6, 16'd2));     // 52
    emit(ri(6'h0A, 5, 5, 16'd1));     // 56
    emit(ri(6'h05, 0, 5, 16'hFFF4));  // 60 back to 52
    emit(ri(6'h2B, 6, 0, 16'h208));   // 64
    emit(HALT);                       // 68
    launch(200);
    chk("R9 bz not taken then bnz taken", rdw(32'h200), 32'h11);
    chk("R9 bz taken, bnz not taken", rdw(32'h204), 32'h55);
    chk("R9 backward loop count", rdw(32'h208), 32'd6);
  endtask

  task automatic t_timing();
    int fc [7];
    logic [31:0] fa [7];
    int nf = 0;
    int nwe = 0;
    logic [31:0] wea = 32'h0;
    int gaps [6] = '{4, 5, 4, 4, 3, 4};
    begin_prog();
    mem[32'h200 >> 2] = 32'hCAFEF00D;
    emit(ri(6'h08, 1, 0, 16'h200));   // 0 alu
    emit(ri(6'h23, 2, 1, 16'd0));     // 4 load
    emit(ri(6'h2B, 2, 1, 16'd4));     // 8 store
    emit(ri(6'h04, 0, 0, 16'd0));     // 12 branch to 16
    emit(32'hFC000000);               // 16 undefined
    emit(rr(6'h20, 3, 1, 1));         // 20 alu
    emit(HALT);                       // 24
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < 40; c++) begin
      if (mem_fetch && nf < 7) begin
        fc[nf] = c;
        fa[nf] = mem_addr;
        nf++;
      end
      if (mem_we) begin
        nwe++;
        wea = mem_addr;
      end
      @(negedge clk);
    end
    chk("R10 fetch count", nf, 7);
    for (int k = 0; k < 6; k++)
      chk($sformatf("R10 gap after instr %0d", k), fc[k+1] - fc[k], gaps[k]);
    for (int k = 0; k < 7; k++)
      chk($sformatf("R2 fetch address %0d", k), fa[k], 32'(4 * k));
    chk("R11 single store strobe", nwe, 1);
    chk("R11 store address", wea, 32'h204);
    chk("R8 stored loaded word", rdw(32'h204), 32'hCAFEF00D);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_rr_ops();
    t_compare();
    t_imm_ops();
    t_r0();
    t_load_store();
    t_branches();
    t_timing();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule